// File: doc/BRIEF.md
# Sync Character Stripping Filter

This block sits in a serial receiver between the character assembler and the receive FIFO, with the CRC accumulator beside it. Each time the assembler presents a character, the filter decides whether that character is written to the FIFO and whether it is fed to the CRC. A matching character is removed from both paths together. A character is matching when it equals an 8-bit compare value and stripping is enabled.

The effect of the strip enable depends on the line mode. In asynchronous, monosync and bisync (8-bit sync) operation, matching characters are dropped. In bisync with the 6-bit sync option, the enable has no effect. In bit-oriented framed (SDLC) mode nothing is stripped, and the enable is passed on as an address-group select for the address matcher.

In monosync with the 6-bit sync option, the last sync character before the data must survive. For this the filter holds one matching character back. When a further sync character arrives, the held one is discarded. When a non-sync character arrives, the held sync character is written first and the data character is written one cycle later. A restart pulse from the receiver discards any character still held or pending.

The state machine has three states:
- PASS: no character held.
- HOLD: one sync character held.
- FLUSH: a data character is pending after a release.

Its transitions are:
- PASS→HOLD: a sync character arrives in lookahead mode.
- HOLD→HOLD: another sync character arrives, and the held one is replaced.
- HOLD→FLUSH: a non-sync character arrives, and the held sync character is released.
- FLUSH→PASS: always, after one cycle.
- Any state→PASS: on restart or reset.

Top module: `sync_strip_filter`

## Requirements
- R1: After reset the filter is in PASS with nothing held: no write occurs without a character, and a character held before reset is never written.
- R2: A character that is not stripped or held is written to the FIFO in the same cycle as `chr_vld`, with `fifo_data` equal to `chr_data`, and `crc_inc` equals `fifo_wr` in every cycle.
- R3: With `strip_en`=1, a character equal to `cmp_val` on all 8 bits is dropped from the FIFO and from the CRC in these modes: async (`mode`=0), monosync (`mode`=1) with `sync6`=0, and bisync (`mode`=2) with `sync6`=0.
- R4: With `strip_en`=0 and no character held, every character is written.
- R5: In bisync with `sync6`=1, `strip_en` has no effect and matching characters are written.
- R6: In SDLC (`mode`=3), no character is stripped, and `addr_grp` equals `strip_en`. In all other modes `addr_grp` is 0.
- R7: In monosync with `sync6`=1 and `strip_en`=1, a run of matching characters writes nothing. On the first non-matching character, the last sync character is written in that cycle and the data character in the next cycle, both with `crc_inc`.
- R8: In monosync with `sync6`=1, the comparison covers all 8 bits, so a character that differs from `cmp_val` only in bit 7 is data.
- R9: A `restart` pulse discards any held or pending character, and the character presented with it is treated as in PASS.
- R10: `chr_vld` is never high in two consecutive cycles. This is a protocol rule on the assembler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_vld | input | 1 | Character valid strobe |
| chr_data | input | 8 | Received character |
| strip_en | input | 1 | Load-inhibit enable (address-group select in SDLC) |
| mode | input | 2 | 0 async, 1 monosync, 2 bisync, 3 SDLC |
| sync6 | input | 1 | 6-bit sync option |
| restart | input | 1 | Data-start pulse: drop held state, new message |
| cmp_val | input | 8 | Compare register |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| crc_inc | output | 1 | Include this character in the CRC |
| addr_grp | output | 1 | Address-group match control for SDLC |

## Verification
A state machine stuck in HOLD shows up on the next non-matching character. In that case a stale sync character appears on `fifo_data` in the same cycle, ahead of the data. A machine that fails to enter HOLD either writes a sync character at once or loses the final sync character, and this is visible on the first data character of the message. A FLUSH that never occurs leaves the data character missing from the FIFO one cycle after the release. A pending character that is not cleared after restart reappears as an extra write within two cycles.

// File: rtl/sync_strip_pkg.sv
package sync_strip_pkg;

    typedef enum logic [1:0] {
        MD_ASYNC  = 2'd0,
        MD_MONO   = 2'd1,
        MD_BISYNC = 2'd2,
        MD_SDLC   = 2'd3
    } line_mode_e;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FLUSH = 2'd2
    } filt_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IN   = 2'd1,
        SRC_HELD = 2'd2,
        SRC_PEND = 2'd3
    } out_src_e;

endpackage

// File: rtl/sync_strip_policy.sv
module sync_strip_policy
    import sync_strip_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0] chr_data,
    input  logic [CW-1:0] cmp_val,
    input  logic          strip_en,
    input  logic [1:0]    mode,
    input  logic          sync6,
    output logic          is_match,
    output logic          look_hit,
    output logic          drop_hit,
    output logic          addr_grp
);

    line_mode_e md;
    logic       look_mode;
    logic       strip_mode;

    always_comb begin
        md = line_mode_e'(mode);
        // full-width compare regardless of the 6-bit option
        is_match   = (chr_data == cmp_val);
        look_mode  = strip_en && (md == MD_MONO) && sync6;
        strip_mode = 1'b0;
        unique case (md)
            MD_ASYNC:  strip_mode = strip_en;
            MD_MONO:   strip_mode = strip_en && !sync6;
            MD_BISYNC: strip_mode = strip_en && !sync6;
            MD_SDLC:   strip_mode = 1'b0;
        endcase
        look_hit = look_mode && is_match;
        drop_hit = strip_mode && is_match;
        addr_grp = (md == MD_SDLC) && strip_en;
    end

endmodule

// File: rtl/sync_strip_store.sv
module sync_strip_store #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_held,
    input  logic          ld_pend,
    input  logic [CW-1:0] chr_data,
    output logic [CW-1:0] held_q,
    output logic [CW-1:0] pend_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            pend_q <= '0;
        end else begin
            if (ld_held) held_q <= chr_data;
            if (ld_pend) pend_q <= chr_data;
        end
    end

endmodule

// File: rtl/sync_strip_fsm.sv
module sync_strip_fsm
    import sync_strip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chr_vld,
    input  logic        restart,
    input  logic        look_hit,
    input  logic        drop_hit,
    output filt_state_e state,
    output logic        ld_held,
    output logic        ld_pend,
    output out_src_e    src
);

    filt_state_e state_nx;
    filt_state_e state_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PASS;
        else        state <= state_nx;
    end

    always_comb begin
        state_eff = restart ? ST_PASS : state;
        state_nx  = state_eff;
        ld_held   = 1'b0;
        ld_pend   = 1'b0;
        src       = SRC_NONE;
        unique case (state_eff)
            ST_PASS: begin
                if (chr_vld) begin
                    if (look_hit) begin
                        ld_held  = 1'b1;
                        state_nx = ST_HOLD;
                    end else if (!drop_hit) begin
                        src = SRC_IN;
                    end
                end
            end
            ST_HOLD: begin
                if (chr_vld) begin
                    if (look_hit) begin
                        ld_held = 1'b1;
                    end else begin
                        src      = SRC_HELD;
                        ld_pend  = 1'b1;
                        state_nx = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                src      = SRC_PEND;
                state_nx = ST_PASS;
            end
            default: state_nx = ST_PASS;
        endcase
    end

endmodule

// File: rtl/sync_strip_filter.sv
module sync_strip_filter
    import sync_strip_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_vld,
    input  logic [CW-1:0] chr_data,
    input  logic          strip_en,
    input  logic [1:0]    mode,
    input  logic          sync6,
    input  logic          restart,
    input  logic [CW-1:0] cmp_val,
    output logic          fifo_wr,
    output logic [CW-1:0] fifo_data,
    output logic          crc_inc,
    output logic          addr_grp
);

    logic          is_match;
    logic          look_hit;
    logic          drop_hit;
    logic          ld_held;
    logic          ld_pend;
    logic [CW-1:0] held_q;
    logic [CW-1:0] pend_q;
    filt_state_e   state;
    out_src_e      src;

    sync_strip_policy #(.CW(CW)) u_policy (
        .chr_data (chr_data),
        .cmp_val  (cmp_val),
        .strip_en (strip_en),
        .mode     (mode),
        .sync6    (sync6),
        .is_match (is_match),
        .look_hit (look_hit),
        .drop_hit (drop_hit),
        .addr_grp (addr_grp)
    );

    sync_strip_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .chr_vld  (chr_vld),
        .restart  (restart),
        .look_hit (look_hit),
        .drop_hit (drop_hit),
        .state    (state),
        .ld_held  (ld_held),
        .ld_pend  (ld_pend),
        .src      (src)
    );

    sync_strip_store #(.CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_held  (ld_held),
        .ld_pend  (ld_pend),
        .chr_data (chr_data),
        .held_q   (held_q),
        .pend_q   (pend_q)
    );

    always_comb begin
        fifo_wr   = 1'b0;
        crc_inc   = 1'b0;
        fifo_data = '0;
        unique case (src)
            SRC_NONE: ;
            SRC_IN: begin
                fifo_wr   = 1'b1;
                crc_inc   = 1'b1;
                fifo_data = chr_data;
            end
            SRC_HELD: begin
                fifo_wr   = 1'b1;
                crc_inc   = 1'b1;
                fifo_data = held_q;
            end
            SRC_PEND: begin
                fifo_wr   = 1'b1;
                crc_inc   = 1'b1;
                fifo_data = pend_q;
            end
        endcase
    end

endmodule

// File: rtl/sync_strip_filter_chk.sv
module sync_strip_filter_chk
    import sync_strip_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chr_vld,
    input logic [CW-1:0] chr_data,
    input logic          strip_en,
    input logic [1:0]    mode,
    input logic          sync6,
    input logic          restart,
    input logic [CW-1:0] cmp_val,
    input logic          fifo_wr,
    input logic [CW-1:0] fifo_data,
    input logic          crc_inc,
    input logic          addr_grp,
    input filt_state_e   state
);

    // R2: the CRC strobe and the FIFO strobe always agree
    a_r2_crc_follows_wr: assert property (@(posedge clk) disable iff (!rst_n)
        crc_inc == fifo_wr);

    // R3: async match with strip enabled never loads
    a_r3_async_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !restart && state == ST_PASS && strip_en
         && mode == 2'd0 && chr_data == cmp_val) |-> !fifo_wr);

    // R4: stripping disabled passes the character through
    a_r4_no_strip_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && state == ST_PASS && !strip_en)
        |-> (fifo_wr && fifo_data == chr_data));

    // R6: SDLC never strips
    a_r6_sdlc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && state == ST_PASS && mode == 2'd3) |-> fifo_wr);

    // R6: address-group select only in SDLC
    a_r6_addr_grp: assert property (@(posedge clk) disable iff (!rst_n)
        addr_grp |-> (mode == 2'd3 && strip_en));

    // R7: release writes the data character on the following cycle
    a_r7_release_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && chr_vld && !restart && chr_data != cmp_val)
        |=> (fifo_wr && fifo_data == $past(chr_data)));

    // R10: characters are never presented back to back
    a_r10_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |=> !chr_vld);

    logic unused_ok;
    assign unused_ok = sync6;

endmodule

bind sync_strip_filter sync_strip_filter_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chr_vld   (chr_vld),
    .chr_data  (chr_data),
    .strip_en  (strip_en),
    .mode      (mode),
    .sync6     (sync6),
    .restart   (restart),
    .cmp_val   (cmp_val),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .crc_inc   (crc_inc),
    .addr_grp  (addr_grp),
    .state     (state)
);

// File: tb/test_sync_strip_filter.sv
module test_sync_strip_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    // fields: req[42:39] mode[38:37] s6[36] en[35] cmp[34:27] d[26:19]
    //         rs[18] w0[17] d0[16:9] w1[8] d1[7:0]
    localparam logic [42:0] TBL [NV] = '{
        {4'd2, 2'd0,1'b0,1'b1,8'h16,8'h41,1'b0, 1'b1,8'h41, 1'b0,8'h00}, // R2
        {4'd3, 2'd0,1'b0,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R3 async
        {4'd4, 2'd0,1'b0,1'b0,8'h16,8'h16,1'b0, 1'b1,8'h16, 1'b0,8'h00}, // R4
        {4'd3, 2'd1,1'b0,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R3 mono
        {4'd5, 2'd2,1'b1,1'b1,8'h16,8'h16,1'b0, 1'b1,8'h16, 1'b0,8'h00}, // R5
        {4'd3, 2'd2,1'b0,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R3 bisync
        {4'd6, 2'd3,1'b0,1'b1,8'h16,8'h16,1'b0, 1'b1,8'h16, 1'b0,8'h00}, // R6
        {4'd7, 2'd1,1'b1,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R7 hold
        {4'd7, 2'd1,1'b1,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R7
        {4'd7, 2'd1,1'b1,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R7
        {4'd7, 2'd1,1'b1,1'b1,8'h16,8'h55,1'b0, 1'b1,8'h16, 1'b1,8'h55}, // R7 release
        {4'd8, 2'd1,1'b1,1'b1,8'h16,8'h96,1'b0, 1'b1,8'h96, 1'b0,8'h00}, // R8
        {4'd7, 2'd1,1'b1,1'b1,8'h16,8'h16,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R7 hold
        {4'd9, 2'd1,1'b1,1'b1,8'h16,8'h41,1'b1, 1'b1,8'h41, 1'b0,8'h00}, // R9
        {4'd7, 2'd1,1'b1,1'b1,8'h7E,8'h7E,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R7
        {4'd7, 2'd1,1'b1,1'b1,8'h7E,8'h00,1'b0, 1'b1,8'h7E, 1'b1,8'h00}  // R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = '0;
    logic       strip_en = 1'b0;
    logic [1:0] mode = '0;
    logic       sync6 = 1'b0;
    logic       restart = 1'b0;
    logic [7:0] cmp_val = '0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       crc_inc;
    logic       addr_grp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_strip_filter i_sync_strip_filter (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .strip_en(strip_en), .mode(mode), .sync6(sync6), .restart(restart),
        .cmp_val(cmp_val), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .crc_inc(crc_inc), .addr_grp(addr_grp)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one character at a falling edge, check same cycle and next cycle
    task automatic send(input string req, input logic [1:0] md, input logic s6,
                        input logic en, input logic [7:0] cv, input logic [7:0] d,
                        input logic rs, input logic w0, input logic [7:0] d0,
                        input logic w1, input logic [7:0] d1);
        @(negedge clk);
        mode = md; sync6 = s6; strip_en = en; cmp_val = cv;
        chr_data = d; restart = rs; chr_vld = 1'b1;
        #2;
        chk(req, {fifo_wr, crc_inc, w0 ? fifo_data : 8'h00}, {w0, w0, d0});
        @(negedge clk);
        chr_vld = 1'b0; restart = 1'b0;
        #2;
        chk(req, {fifo_wr, crc_inc, w1 ? fifo_data : 8'h00}, {w1, w1, d1});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state, nothing written
        chk("R1", {fifo_wr, crc_inc, fifo_data}, 10'h000);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", {fifo_wr, crc_inc, fifo_data}, 10'h000);

        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            string       tag;
            v   = TBL[i];
            tag = $sformatf("R%0d", v[42:39]);
            send(tag, v[38:37], v[36], v[35], v[34:27], v[26:19], v[18],
                 v[17], v[16:9], v[8], v[7:0]);
        end

        // R6: address-group select follows strip_en only in SDLC
        @(negedge clk);
        mode = 2'd3; strip_en = 1'b1; #2;
        chk("R6", {9'd0, addr_grp}, 10'd1);
        strip_en = 1'b0; #2;
        chk("R6", {9'd0, addr_grp}, 10'd0);
        mode = 2'd0; strip_en = 1'b1; #2;
        chk("R6", {9'd0, addr_grp}, 10'd0);

        // R1: held sync character lost across reset
        send("R1", 2'd1, 1'b1, 1'b1, 8'h16, 8'h16, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        send("R1", 2'd1, 1'b1, 1'b1, 8'h16, 8'h41, 1'b0, 1'b1, 8'h41, 1'b0, 8'h00);

        // R8: differs only in bit 7 from a 6-bit-looking pattern
        send("R8", 2'd1, 1'b1, 1'b1, 8'h3F, 8'hBF, 1'b0, 1'b1, 8'hBF, 1'b0, 8'h00);

        // R5: bisync 6-bit, several matching characters in a row all written
        send("R5", 2'd2, 1'b1, 1'b1, 8'h3F, 8'h3F, 1'b0, 1'b1, 8'h3F, 1'b0, 8'h00);
        send("R5", 2'd2, 1'b1, 1'b1, 8'h3F, 8'h3F, 1'b0, 1'b1, 8'h3F, 1'b0, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule